// File: doc/BRIEF.md
# Shared-Term Constant Multiplier Bank

The block multiplies one signed input sample by thirteen fixed odd integer coefficients at the same time. Its natural use is the coefficient side of a transposed-form FIR filter. It contains no multiplier operators. It first forms a small set of odd multiples of the input: 3, 5, 7, 9, 11 and 13 times the sample. Each coefficient product is then assembled from two or three of these terms, shifted left by wiring and added or subtracted.

The whole bank spends 22 add/subtract operations. No output lies more than three cascaded adders from the input. The network is purely combinational, so a new sample shows up on every output within the same cycle it is applied.

Every output is a full-precision two's-complement product. It is wide enough that no input value can overflow it.

Top module: `const_mult_bank`

## Requirements
- R1: Output lane k equals the signed input times coefficient C_k, exact in PROD_W-bit two's complement. The lanes in index order 0..12 carry 355, 327, 505, 291, 199, 35, 499, 331, 133, 699, 1943, 2987, 3395.
- R2: An input of zero drives every lane to zero.
- R3: The extreme inputs 32767 and -32768 give exact products on every lane, with no wrap. For example, lane 12 gives -111247360 for -32768.
- R4: For a non-zero input, the sign bit (bit PROD_W-1) of every lane equals the sign bit of the input.
- R5: Bit 0 of every lane equals bit 0 of the input, because every coefficient is odd.
- R6: For any input X other than -32768, each lane's product for -X is the two's-complement negation of its product for X.
- R7: The block holds no state. A change of the input appears on all lanes without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sample | input | IN_W (16) | Signed two's-complement input sample |
| prod | output | 13 x PROD_W (13 x 28) | Packed array of signed products; lane k is prod[k] |

## Verification
The shared sub-terms feed several lanes at once. A single faulty shared term therefore corrupts several products in the same cycle, and one input pattern checks all thirteen lanes together. The input range is swept exhaustively, so every lane is judged against the exact arithmetic product for every sample.

The most negative input brings the widest magnitude, the sign rule and the odd-LSB rule into one cycle. That value is driven on its own and each property is judged separately. Negation pairs are also driven back to back, so that a lane that handles one sign of its subtract path wrongly shows up as an asymmetric result.

// File: rtl/cmb_pkg.sv
package cmb_pkg;

    localparam int unsigned NUM_K  = 13;
    localparam int unsigned NUM_T  = 8;
    localparam int unsigned TERM_G = 4;
    localparam int unsigned PROD_G = 12;

    typedef enum logic [2:0] {
        T_X    = 3'd0,
        T_3    = 3'd1,
        T_5    = 3'd2,
        T_7    = 3'd3,
        T_9    = 3'd4,
        T_11   = 3'd5,
        T_13   = 3'd6,
        T_NONE = 3'd7
    } term_e;

    typedef struct packed {
        term_e      a;
        logic [3:0] sha;
        term_e      b;
        logic [3:0] shb;
        logic       subb;
        term_e      c;
        logic [3:0] shc;
        logic       subc;
    } recipe_t;

    function automatic recipe_t mk(term_e a, int sa, term_e b, int sb, bit nb,
                                   term_e c, int sc, bit nc);
        recipe_t r;
        r.a    = a;
        r.sha  = 4'(sa);
        r.b    = b;
        r.shb  = 4'(sb);
        r.subb = nb;
        r.c    = c;
        r.shc  = 4'(sc);
        r.subc = nc;
        return r;
    endfunction

    function automatic recipe_t recipe(int k);
        case (k)
            0:       return mk(T_3,  0,  T_11, 5, 1'b0, T_NONE, 0,  1'b0);
            1:       return mk(T_7,  0,  T_5,  6, 1'b0, T_NONE, 0,  1'b0);
            2:       return mk(T_X,  9,  T_7,  0, 1'b1, T_NONE, 0,  1'b0);
            3:       return mk(T_3,  0,  T_9,  5, 1'b0, T_NONE, 0,  1'b0);
            4:       return mk(T_7,  0,  T_3,  6, 1'b0, T_NONE, 0,  1'b0);
            5:       return mk(T_3,  0,  T_X,  5, 1'b0, T_NONE, 0,  1'b0);
            6:       return mk(T_X,  9,  T_13, 0, 1'b1, T_NONE, 0,  1'b0);
            7:       return mk(T_11, 0,  T_5,  6, 1'b0, T_NONE, 0,  1'b0);
            8:       return mk(T_5,  0,  T_X,  7, 1'b0, T_NONE, 0,  1'b0);
            9:       return mk(T_11, 6,  T_5,  0, 1'b1, T_NONE, 0,  1'b0);
            10:      return mk(T_X,  11, T_9,  0, 1'b1, T_3,    5,  1'b1);
            11:      return mk(T_3,  10, T_3,  5, 1'b1, T_11,   0,  1'b0);
            default: return mk(T_3,  0,  T_5,  6, 1'b0, T_3,    10, 1'b0);
        endcase
    endfunction

    function automatic int coef(int k);
        case (k)
            0:       return 355;
            1:       return 327;
            2:       return 505;
            3:       return 291;
            4:       return 199;
            5:       return 35;
            6:       return 499;
            7:       return 331;
            8:       return 133;
            9:       return 699;
            10:      return 1943;
            11:      return 2987;
            default: return 3395;
        endcase
    endfunction

endpackage

// File: rtl/cmb_odd_terms.sv
module cmb_odd_terms
    import cmb_pkg::*;
#(
    parameter int unsigned IN_W   = 16,
    parameter int unsigned TERM_W = IN_W + TERM_G
) (
    input  logic [IN_W-1:0]               x,
    output logic [NUM_T-1:0][TERM_W-1:0]  terms
);

    logic [NUM_T-1:0][TERM_W-1:0] terms_d;
    logic [TERM_W-1:0]            xe;

    always_comb begin
        xe      = {{(TERM_W-IN_W){x[IN_W-1]}}, x};
        terms_d = '0;
        terms_d[T_X]  = xe;
        terms_d[T_3]  = xe + (xe << 1);
        terms_d[T_5]  = xe + (xe << 2);
        terms_d[T_7]  = (xe << 3) - xe;
        terms_d[T_9]  = xe + (xe << 3);
        terms_d[T_11] = terms_d[T_9] + (xe << 1);
        terms_d[T_13] = terms_d[T_9] + (xe << 2);
    end

    assign terms = terms_d;

endmodule

// File: rtl/cmb_shift_add.sv
module cmb_shift_add
    import cmb_pkg::*;
#(
    parameter int unsigned TERM_W = 20,
    parameter int unsigned PROD_W = 28,
    parameter recipe_t     RECIPE = '0
) (
    input  logic [NUM_T-1:0][TERM_W-1:0] terms,
    output logic [PROD_W-1:0]            prod
);

    localparam int unsigned EXT_W = PROD_W - TERM_W;

    logic [PROD_W-1:0] opa_d, opb_d, pair_d;

    always_comb begin
        opa_d  = {{EXT_W{terms[RECIPE.a][TERM_W-1]}}, terms[RECIPE.a]} << RECIPE.sha;
        opb_d  = {{EXT_W{terms[RECIPE.b][TERM_W-1]}}, terms[RECIPE.b]} << RECIPE.shb;
        pair_d = RECIPE.subb ? (opa_d - opb_d) : (opa_d + opb_d);
    end

    generate
        if (RECIPE.c != T_NONE) begin : g_three
            logic [PROD_W-1:0] opc_d;
            always_comb begin
                opc_d = {{EXT_W{terms[RECIPE.c][TERM_W-1]}}, terms[RECIPE.c]} << RECIPE.shc;
                prod  = RECIPE.subc ? (pair_d - opc_d) : (pair_d + opc_d);
            end
        end else begin : g_two
            assign prod = pair_d;
        end
    endgenerate

endmodule

// File: rtl/const_mult_bank.sv
module const_mult_bank
    import cmb_pkg::*;
#(
    parameter int unsigned IN_W = 16
) (
    input  logic [IN_W-1:0]              sample,
    output logic [NUM_K-1:0][IN_W+PROD_G-1:0] prod
);

    localparam int unsigned TERM_W = IN_W + TERM_G;
    localparam int unsigned PROD_W = IN_W + PROD_G;

    logic [NUM_T-1:0][TERM_W-1:0] terms;

    cmb_odd_terms #(
        .IN_W   (IN_W),
        .TERM_W (TERM_W)
    ) u_terms (
        .x     (sample),
        .terms (terms)
    );

    generate
        for (genvar k = 0; k < NUM_K; k++) begin : g_lane
            cmb_shift_add #(
                .TERM_W (TERM_W),
                .PROD_W (PROD_W),
                .RECIPE (recipe(k))
            ) u_lane (
                .terms (terms),
                .prod  (prod[k])
            );
        end
    endgenerate

endmodule

// File: rtl/cmb_checker.sv
module cmb_checker
    import cmb_pkg::*;
#(
    parameter int unsigned IN_W   = 16,
    parameter int unsigned PROD_W = IN_W + PROD_G
) (
    input logic [IN_W-1:0]              sample,
    input logic [NUM_K-1:0][PROD_W-1:0] prod
);

    always_comb begin
        for (int k = 0; k < NUM_K; k++) begin
            // R1
            exact_product_chk: assert (longint'($signed(prod[k])) ==
                                       longint'($signed(sample)) * longint'(coef(k)));
            // R5
            odd_lsb_chk: assert (prod[k][0] == sample[0]);
            // R4
            if (sample != '0) begin
                sign_follow_chk: assert (prod[k][PROD_W-1] == sample[IN_W-1]);
            end
        end
        // R2
        if (sample == '0) begin
            zero_in_chk: assert (prod == '0);
        end
    end

endmodule

bind const_mult_bank cmb_checker #(
    .IN_W   (IN_W),
    .PROD_W (PROD_W)
) u_cmb_checker (
    .sample (sample),
    .prod   (prod)
);

// File: tb/const_mult_bank_bench.sv
module const_mult_bank_bench;

    localparam int IN_W   = 16;
    localparam int PROD_W = 28;
    localparam int NK     = 13;

    logic                         clk = 1'b0;
    logic [IN_W-1:0]              sample = '0;
    logic [NK-1:0][PROD_W-1:0]    prod;

    int total = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 0;

    int coefs [NK] = '{355, 327, 505, 291, 199, 35, 499, 331, 133, 699, 1943, 2987, 3395};

    always #5 clk = ~clk;

    const_mult_bank #(.IN_W(IN_W)) u_const_mult_bank (
        .sample (sample),
        .prod   (prod)
    );

    function automatic longint lane(int k);
        return longint'($signed(prod[k]));
    endfunction

    task automatic check(string tag, int k, longint got, longint exp);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s lane %0d x=%0d got %0d expected %0d",
                     tag, k, $signed(sample), got, exp);
        end
    endtask

    task automatic drive(int x);
        @(posedge clk);
        sample <= IN_W'(x);
        @(negedge clk);
    endtask

    task automatic check_all(string tag, int x);
        for (int k = 0; k < NK; k++)
            check(tag, k, lane(k), longint'(x) * longint'(coefs[k]));
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            fails++;
            total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        longint saved [NK];
        // R2: zero input, all lanes zero
        drive(0);
        for (int k = 0; k < NK; k++) check("R2", k, lane(k), 0);

        // R3: extremes
        drive(32767);
        check_all("R3", 32767);
        drive(-32768);
        check_all("R3", -32768);
        check("R3", 12, lane(12), -64'sd111247360);

        // R1, R4, R5: exhaustive sweep
        for (int x = -32768; x < 32768; x++) begin
            drive(x);
            check_all("R1", x);
            for (int k = 0; k < NK; k++) begin
                check("R5", k, longint'(prod[k][0]), longint'(x & 1));
                if (x != 0)
                    check("R4", k, longint'(prod[k][PROD_W-1]), (x < 0) ? 1 : 0);
            end
        end

        // R6: negation symmetry
        for (int x = 1; x < 32768; x += 997) begin
            drive(x);
            for (int k = 0; k < NK; k++) saved[k] = lane(k);
            drive(-x);
            for (int k = 0; k < NK; k++) check("R6", k, lane(k), -saved[k]);
        end

        // R7: outputs follow the input before any further clock edge
        @(posedge clk);
        sample <= 16'sd1234;
        #1;
        for (int k = 0; k < NK; k++)
            check("R7", k, lane(k), longint'(1234) * longint'(coefs[k]));
        sample <= -16'sd4321;
        #1;
        for (int k = 0; k < NK; k++)
            check("R7", k, lane(k), longint'(-4321) * longint'(coefs[k]));

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule